// File: doc/BRIEF.md
# Precise Exception Selector and Handler Vector Unit

This unit sits at the commit point of an in-order RISC pipeline that runs either 32-bit or 64-bit addressing. Every pipeline stage presents a valid bit, the address of its instruction, a delay-slot flag, a 64-bit-access flag and a 21-bit vector of exception requests. The unit finds the oldest valid stage that raises anything. Within that stage it keeps only the most urgent request. It then reports a cause code, the handler address and the restart address, together with a flush mask for the faulting instruction and everything younger.

The unit also owns the small piece of processor state that an exception changes: the exception-level flag, the user/kernel mode and the interrupt enable. Taking an exception forces kernel mode and masks interrupts. The state that was in force before is kept aside, and a one-cycle restore input brings it back. All inputs and outputs are plain control pins. The pipeline must accept a take pulse in the cycle it appears, so there is no back-pressure. Asynchronous events (hard reset, soft reset, NMI, interrupt) are presented by the pipeline on the oldest stage.

Top module: `exc_commit_unit`

## Requirements
- R1: Stage 0 is the oldest stage. The selected instruction is the lowest-numbered stage whose valid bit is 1 and whose request vector is non-zero. Requests from stages with valid 0, and from every stage younger than the selected one, are discarded. With no such stage, take_o stays 0.
- R2: Request bit n is urgent in the order of n: bit 0 is the most urgent. The bits are 0 hard reset, 1 soft reset, 2 NMI, 3 fetch address error, 4 fetch TLB refill, 5 fetch TLB invalid, 6 fetch bus error, 7 system call, 8 breakpoint, 9 coprocessor unusable, 10 reserved instruction, 11 trap, 12 overflow, 13 floating point, 14 data address error, 15 data TLB refill, 16 data TLB invalid, 17 TLB modified, 18 watch, 19 data bus error, 20 interrupt. cause_o is the index of the lowest set bit of the selected stage.
- R3: Causes 0, 1 and 2 vector to 0xBFC0_0000, whatever bev_i is.
- R4: Every other cause vectors to a base plus an offset. The base is 0x8000_0000 when bev_i is 0 and 0xBFC0_0200 when bev_i is 1. The offset is 0x180 unless R5 applies.
- R5: Causes 4 and 15 (TLB refill) use offset 0x000, or 0x080 when the selected stage's 64-bit-access flag is 1, provided exl_o is 0.
- R6: With mode64_i 1, the upper 32 bits of vector_o are all ones. With mode64_i 0, they are zero.
- R7: epc_o is the selected stage's address. If that stage's delay-slot flag is 1, epc_o is the address minus 4 and bd_o is 1; otherwise bd_o is 0.
- R8: flush_o has bit t set exactly for t greater than or equal to the selected stage index.
- R9: take_o pulses for one cycle, in the cycle after the requests are presented. Requests present while take_o is 1 are ignored.
- R10: A take sets exl_o to 1, kernel_o to 1 and ie_o to 0. The prior mode and interrupt enable are saved. A status load (sts_ld_i) writes user mode and interrupt enable. kernel_o equals exl_o OR NOT user.
- R11: While exl_o is 1, a further take leaves epc_o, bd_o and the saved state unchanged, and refill causes use offset 0x180.
- R12: eret_i restores the saved mode and interrupt enable and clears exl_o in one cycle. A take in the same cycle has precedence.
- R13: After reset, take_o, exl_o, ie_o and all address outputs are 0, and kernel_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_vld_i | input | NST | Per-stage instruction valid |
| stg_exc_i | input | NST*21 | Per-stage request vectors, stage s at bits s*21 and up |
| stg_pc_i | input | NST*AW | Per-stage instruction address |
| stg_bd_i | input | NST | Per-stage delay-slot flag |
| stg_x64_i | input | NST | Per-stage 64-bit access flag |
| mode64_i | input | 1 | 64-bit addressing mode |
| bev_i | input | 1 | Boot vector select |
| sts_ld_i | input | 1 | Load user mode and interrupt enable |
| sts_user_i | input | 1 | User mode value to load |
| sts_ie_i | input | 1 | Interrupt enable value to load |
| eret_i | input | 1 | Restore saved state, clear exception level |
| take_o | output | 1 | Exception taken pulse |
| cause_o | output | 5 | Cause code (request bit index) |
| flush_o | output | NST | Stages to flush |
| vector_o | output | AW | Handler address for the next fetch |
| epc_o | output | AW | Restart address |
| bd_o | output | 1 | Restart address was adjusted for a delay slot |
| exl_o | output | 1 | Exception level |
| kernel_o | output | 1 | Kernel mode in force |
| ie_o | output | 1 | Interrupts enabled |

## Verification
The hardest case to reach from the ports is the nested exception. It needs exl_o to be 1 and a refill request to arrive before any restore. Only then do the unchanged restart address and the switch to offset 0x180 show. The stimulus first loads user mode with interrupts on, takes a system call, and withholds eret_i. It then raises a data refill on a younger stage, and finally restores, checking that the state saved by the first take is the one that comes back.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NEXC = 21;
  localparam int CW   = 5;

  typedef enum logic [CW-1:0] {
    EX_HARD_RST = 5'd0,  EX_SOFT_RST = 5'd1,  EX_NMI      = 5'd2,
    EX_F_ADDR   = 5'd3,  EX_F_REFILL = 5'd4,  EX_F_INVAL  = 5'd5,
    EX_F_BUS    = 5'd6,  EX_SYSCALL  = 5'd7,  EX_BRKPT    = 5'd8,
    EX_COP_UNU  = 5'd9,  EX_RSV_INS  = 5'd10, EX_TRAP     = 5'd11,
    EX_OVFL     = 5'd12, EX_FLOAT    = 5'd13, EX_D_ADDR   = 5'd14,
    EX_D_REFILL = 5'd15, EX_D_INVAL  = 5'd16, EX_D_MOD    = 5'd17,
    EX_WATCH    = 5'd18, EX_D_BUS    = 5'd19, EX_IRQ      = 5'd20
  } exc_code_e;

  function automatic logic is_fixed(exc_code_e c);
    return (c == EX_HARD_RST) || (c == EX_SOFT_RST) || (c == EX_NMI);
  endfunction

  function automatic logic is_refill(exc_code_e c);
    return (c == EX_F_REFILL) || (c == EX_D_REFILL);
  endfunction
endpackage

// File: rtl/exc_select.sv
module exc_select
  import exc_pkg::*;
#(
  parameter int NST = 3,
  parameter int AW  = 64
) (
  input  logic [NST-1:0]      vld,
  input  logic [NST*NEXC-1:0] flags,
  input  logic [NST*AW-1:0]   pcs,
  input  logic [NST-1:0]      bds,
  input  logic [NST-1:0]      x64s,
  output logic                hit,
  output exc_code_e           code,
  output logic [AW-1:0]       pc,
  output logic                bd,
  output logic                x64,
  output logic [NST-1:0]      flush
);
  logic [NST-1:0]         live;
  logic [NST-1:0][CW-1:0] stg_code;

  function automatic logic [CW-1:0] lowest_set(logic [NEXC-1:0] f);
    logic [CW-1:0] r;
    r = '0;
    for (int i = NEXC - 1; i >= 0; i--) begin
      if (f[i]) r = CW'(i);
    end
    return r;
  endfunction

  for (genvar s = 0; s < NST; s++) begin : g_stage
    assign live[s]     = vld[s] & (|flags[s*NEXC +: NEXC]);
    assign stg_code[s] = lowest_set(flags[s*NEXC +: NEXC]);
  end

  always_comb begin
    hit   = 1'b0;
    code  = EX_HARD_RST;
    pc    = '0;
    bd    = 1'b0;
    x64   = 1'b0;
    flush = '0;
    for (int s = NST - 1; s >= 0; s--) begin
      if (live[s]) begin
        hit  = 1'b1;
        code = exc_code_e'(stg_code[s]);
        pc   = pcs[s*AW +: AW];
        bd   = bds[s];
        x64  = x64s[s];
        for (int t = 0; t < NST; t++) flush[t] = (t >= s);
      end
    end
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter int AW = 64
) (
  input  exc_code_e     code,
  input  logic          bev,
  input  logic          mode64,
  input  logic          x64,
  input  logic          exl,
  output logic [AW-1:0] vec
);
  localparam logic [31:0] FIXED_VEC = 32'hBFC0_0000;
  localparam logic [31:0] BASE_RUN  = 32'h8000_0000;
  localparam logic [31:0] BASE_BOOT = 32'hBFC0_0200;
  localparam logic [31:0] OFF_GEN   = 32'h0000_0180;
  localparam logic [31:0] OFF_XREF  = 32'h0000_0080;
  localparam logic [31:0] OFF_REF   = 32'h0000_0000;

  logic [31:0] v32;
  logic [31:0] off;

  always_comb begin
    off = OFF_GEN;
    if (is_refill(code) && !exl) off = x64 ? OFF_XREF : OFF_REF;
    if (is_fixed(code)) v32 = FIXED_VEC;
    else                v32 = (bev ? BASE_BOOT : BASE_RUN) + off;
  end

  assign vec = mode64 ? {{(AW-32){v32[31]}}, v32} : {{(AW-32){1'b0}}, v32};
endmodule

// File: rtl/exc_status.sv
module exc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic eret,
  input  logic ld,
  input  logic ld_user,
  input  logic ld_ie,
  output logic exl,
  output logic user,
  output logic ie
);
  logic sv_user, sv_ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exl     <= 1'b0;
      user    <= 1'b0;
      ie      <= 1'b0;
      sv_user <= 1'b0;
      sv_ie   <= 1'b0;
    end else if (take) begin
      exl  <= 1'b1;
      user <= 1'b0;
      ie   <= 1'b0;
      if (!exl) begin
        sv_user <= user;
        sv_ie   <= ie;
      end
    end else if (eret) begin
      exl  <= 1'b0;
      user <= sv_user;
      ie   <= sv_ie;
    end else if (ld) begin
      user <= ld_user;
      ie   <= ld_ie;
    end
  end
endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
  import exc_pkg::*;
#(
  parameter int NST = 3,
  parameter int AW  = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NST-1:0]      stg_vld_i,
  input  logic [NST*NEXC-1:0] stg_exc_i,
  input  logic [NST*AW-1:0]   stg_pc_i,
  input  logic [NST-1:0]      stg_bd_i,
  input  logic [NST-1:0]      stg_x64_i,
  input  logic                mode64_i,
  input  logic                bev_i,
  input  logic                sts_ld_i,
  input  logic                sts_user_i,
  input  logic                sts_ie_i,
  input  logic                eret_i,
  output logic                take_o,
  output logic [CW-1:0]       cause_o,
  output logic [NST-1:0]      flush_o,
  output logic [AW-1:0]       vector_o,
  output logic [AW-1:0]       epc_o,
  output logic                bd_o,
  output logic                exl_o,
  output logic                kernel_o,
  output logic                ie_o
);
  localparam logic [AW-1:0] INSN_BYTES = AW'(4);

  logic          sel_hit, sel_bd, sel_x64, req, exl, user;
  exc_code_e     sel_code;
  logic [AW-1:0] sel_pc, sel_vec;
  logic [NST-1:0] sel_flush;

  exc_select #(.NST(NST), .AW(AW)) u_sel (
    .vld(stg_vld_i), .flags(stg_exc_i), .pcs(stg_pc_i), .bds(stg_bd_i),
    .x64s(stg_x64_i), .hit(sel_hit), .code(sel_code), .pc(sel_pc),
    .bd(sel_bd), .x64(sel_x64), .flush(sel_flush)
  );

  exc_vector #(.AW(AW)) u_vec (
    .code(sel_code), .bev(bev_i), .mode64(mode64_i), .x64(sel_x64),
    .exl(exl), .vec(sel_vec)
  );

  // a request seen while the previous take is still flushing is dropped
  assign req = sel_hit & ~take_o;

  exc_status u_sts (
    .clk(clk), .rst_n(rst_n), .take(req), .eret(eret_i), .ld(sts_ld_i),
    .ld_user(sts_user_i), .ld_ie(sts_ie_i), .exl(exl), .user(user), .ie(ie_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_o   <= 1'b0;
      cause_o  <= '0;
      flush_o  <= '0;
      vector_o <= '0;
      epc_o    <= '0;
      bd_o     <= 1'b0;
    end else begin
      take_o <= req;
      if (req) begin
        cause_o  <= sel_code;
        flush_o  <= sel_flush;
        vector_o <= sel_vec;
        if (!exl) begin
          epc_o <= sel_bd ? (sel_pc - INSN_BYTES) : sel_pc;
          bd_o  <= sel_bd;
        end
      end
    end
  end

  assign exl_o    = exl;
  assign kernel_o = exl | ~user;
endmodule

// File: rtl/exc_commit_chk.sv
module exc_commit_chk #(
  parameter int NST = 3,
  parameter int AW  = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NST-1:0] stg_vld_i,
  input logic           eret_i,
  input logic           take_o,
  input logic [4:0]     cause_o,
  input logic [NST-1:0] flush_o,
  input logic [AW-1:0]  vector_o,
  input logic [AW-1:0]  epc_o,
  input logic           exl_o,
  input logic           ie_o
);
  // R1
  idle_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|stg_vld_i) |=> !take_o);
  // R3
  fixed_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && cause_o <= 5'd2) |-> vector_o[31:0] == 32'hBFC0_0000);
  // R8
  flush_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> flush_o[NST-1]);
  // R9
  take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);
  // R10
  take_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (exl_o && !ie_o));
  // R11
  nested_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && $past(exl_o)) |-> $stable(epc_o));
  // R12
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && !(|stg_vld_i) && !take_o) |=> !exl_o);
endmodule

bind exc_commit_unit exc_commit_chk #(.NST(NST), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stg_vld_i(stg_vld_i), .eret_i(eret_i),
  .take_o(take_o), .cause_o(cause_o), .flush_o(flush_o), .vector_o(vector_o),
  .epc_o(epc_o), .exl_o(exl_o), .ie_o(ie_o)
);

// File: tb/exc_commit_unit_tb_top.sv
module exc_commit_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NST = 3;
  localparam int AW  = 64;
  localparam int NX  = 21;

  typedef struct packed {
    logic [NX-1:0] f0, f1, f2;
    logic [2:0]    vld, bd, x64;
    logic          bev, m64;
    logic [4:0]    cause;
    logic [63:0]   vec, epc;
    logic          ebd;
    logic [2:0]    flush;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{21'h80, 21'h0, 21'h0, 3'b001, 3'b000, 3'b000, 1'b0, 1'b0, 5'd7,
      64'h8000_0180, 64'h40_0100, 1'b0, 3'b111},
    '{21'h1, 21'h1100, 21'h100000, 3'b110, 3'b000, 3'b000, 1'b0, 1'b0, 5'd8,
      64'h8000_0180, 64'h40_0110, 1'b0, 3'b110},
    '{21'h8000, 21'h0, 21'h0, 3'b001, 3'b000, 3'b000, 1'b1, 1'b1, 5'd15,
      64'hFFFF_FFFF_BFC0_0200, 64'h40_0100, 1'b0, 3'b111},
    '{21'h0, 21'h0, 21'h10, 3'b100, 3'b000, 3'b100, 1'b0, 1'b1, 5'd4,
      64'hFFFF_FFFF_8000_0080, 64'h40_0120, 1'b0, 3'b100},
    '{21'h100004, 21'h0, 21'h0, 3'b001, 3'b000, 3'b000, 1'b1, 1'b1, 5'd2,
      64'hFFFF_FFFF_BFC0_0000, 64'h40_0100, 1'b0, 3'b111},
    '{21'h100081, 21'h0, 21'h0, 3'b001, 3'b000, 3'b000, 1'b0, 1'b0, 5'd0,
      64'hBFC0_0000, 64'h40_0100, 1'b0, 3'b111},
    '{21'h0, 21'h400, 21'h0, 3'b010, 3'b010, 3'b000, 1'b0, 1'b0, 5'd10,
      64'h8000_0180, 64'h40_010C, 1'b1, 3'b110},
    '{21'h40000, 21'h80, 21'h0, 3'b011, 3'b000, 3'b000, 1'b0, 1'b0, 5'd18,
      64'h8000_0180, 64'h40_0100, 1'b0, 3'b111},
    '{21'h0, 21'h0, 21'h100000, 3'b100, 3'b000, 3'b000, 1'b1, 1'b0, 5'd20,
      64'hBFC0_0380, 64'h40_0120, 1'b0, 3'b100},
    '{21'h10, 21'h0, 21'h0, 3'b001, 3'b000, 3'b001, 1'b1, 1'b0, 5'd4,
      64'hBFC0_0280, 64'h40_0100, 1'b0, 3'b111}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NST-1:0] stg_vld_i = '0, stg_bd_i = '0, stg_x64_i = '0;
  logic [NST*NX-1:0] stg_exc_i = '0;
  logic [NST*AW-1:0] stg_pc_i;
  logic mode64_i = 0, bev_i = 0, sts_ld_i = 0, sts_user_i = 0, sts_ie_i = 0, eret_i = 0;
  logic take_o, bd_o, exl_o, kernel_o, ie_o;
  logic [4:0] cause_o;
  logic [NST-1:0] flush_o;
  logic [AW-1:0] vector_o, epc_o;
  int n_chk = 0, n_err = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign stg_pc_i = {64'h40_0120, 64'h40_0110, 64'h40_0100};

  exc_commit_unit #(.NST(NST), .AW(AW)) dut_i (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [NX-1:0] f0, f1, f2, logic [2:0] v, b, x);
    stg_exc_i = {f2, f1, f0};
    stg_vld_i = v;
    stg_bd_i  = b;
    stg_x64_i = x;
  endtask

  task automatic idle();
    drive('0, '0, '0, '0, '0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog act=running exp=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 take", take_o, 0);
    chk("R13 exl", exl_o, 0);
    chk("R13 kernel", kernel_o, 1);
    chk("R13 ie", ie_o, 0);
    chk("R13 vector", vector_o, 0);
    chk("R13 epc", epc_o, 0);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].f0, TBL[i].f1, TBL[i].f2, TBL[i].vld, TBL[i].bd, TBL[i].x64);
      bev_i = TBL[i].bev;
      mode64_i = TBL[i].m64;
      @(negedge clk);
      chk($sformatf("R9 take v%0d", i), take_o, 1);
      chk($sformatf("R1/R2 cause v%0d", i), cause_o, TBL[i].cause);
      chk($sformatf("R3-R6 vector v%0d", i), vector_o, TBL[i].vec);
      chk($sformatf("R7 epc v%0d", i), epc_o, TBL[i].epc);
      chk($sformatf("R7 bd v%0d", i), bd_o, TBL[i].ebd);
      chk($sformatf("R8 flush v%0d", i), flush_o, TBL[i].flush);
      idle();
      eret_i = 1'b1;
      @(negedge clk);
      eret_i = 1'b0;
      chk($sformatf("R9 pulse v%0d", i), take_o, 0);
      chk($sformatf("R12 exl v%0d", i), exl_o, 0);
    end

    // R1 no valid stage: nothing taken
    bev_i = 0;
    mode64_i = 0;
    drive(21'h80, 21'h80, 21'h80, 3'b000, '0, '0);
    @(negedge clk);
    chk("R1 invalid ignored", take_o, 0);
    chk("R1 invalid exl", exl_o, 0);
    idle();

    // R10 status load, then take, nested R11, restore R12
    sts_ld_i = 1;
    sts_user_i = 1;
    sts_ie_i = 1;
    @(negedge clk);
    sts_ld_i = 0;
    chk("R10 load kernel", kernel_o, 0);
    chk("R10 load ie", ie_o, 1);
    drive(21'h80, 21'h0, 21'h0, 3'b001, '0, '0);
    @(negedge clk);
    idle();
    chk("R10 take kernel", kernel_o, 1);
    chk("R10 take ie", ie_o, 0);
    chk("R10 take exl", exl_o, 1);
    chk("R10 epc", epc_o, 64'h40_0100);
    @(negedge clk);
    drive(21'h0, 21'h0, 21'h8000, 3'b100, 3'b100, '0);
    @(negedge clk);
    idle();
    chk("R11 nested take", take_o, 1);
    chk("R11 nested vector", vector_o, 64'h8000_0180);
    chk("R11 nested epc", epc_o, 64'h40_0100);
    chk("R11 nested bd", bd_o, 0);
    eret_i = 1;
    @(negedge clk);
    eret_i = 0;
    chk("R12 restore exl", exl_o, 0);
    chk("R12 restore kernel", kernel_o, 0);
    chk("R12 restore ie", ie_o, 1);

    // R12 take and restore in the same cycle: take wins
    drive(21'h80, 21'h0, 21'h0, 3'b001, '0, '0);
    eret_i = 1;
    @(negedge clk);
    eret_i = 0;
    idle();
    chk("R12 take precedence", exl_o, 1);
    eret_i = 1;
    @(negedge clk);
    eret_i = 0;

    // R9 held request: take, drop, take
    drive(21'h400, 21'h0, 21'h0, 3'b001, '0, '0);
    @(negedge clk);
    chk("R9 held first", take_o, 1);
    @(negedge clk);
    chk("R9 held ignored", take_o, 0);
    @(negedge clk);
    chk("R9 held again", take_o, 1);
    idle();
    eret_i = 1;
    @(negedge clk);
    eret_i = 0;
    chk("R12 final exl", exl_o, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule